// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns bytes written by a host into asynchronous serial frames on a single output line. The host sets the character format in an 8-bit line control register and the bit rate in a 16-bit divisor. It then writes a byte into a one-deep holding register. The framer sends a low start bit, then 5 to 8 data bits with the least significant bit first. An optional parity bit follows, and the frame closes with a high stop period of one, one and a half or two bit times. The line rests high between frames.

Timing comes from an internal tick generator. It divides the system clock by the divisor and gives one oversample tick every `max(divisor,1)` clocks. Every bit lasts a fixed number of ticks (16 by default). The divisor's two bytes share addresses with the holding register. A divisor-select bit in the control register chooses which is written. Two status outputs tell the host whether the holding register can take a new byte and whether the transmitter has fully drained.

Top module: `uart_tx_framer`

Register addresses on `wr_addr`: 0 is the holding register, or the divisor low byte while control bit 7 is 1. 1 is the divisor high byte while control bit 7 is 1, and is ignored otherwise. 3 is the line control register. 2 is ignored.

## Requirements
- R1: After reset `txd` is 1, `thr_empty` is 1 and `tx_idle` is 1. The control register holds 8'h03 (8 data bits, no parity, one stop bit, divisor select off) and the divisor holds 0.
- R2: Control bits [1:0] set the character length: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8 data bits.
- R3: A frame starts with a low start bit, and its data bits go out least significant bit first. The line is high when no frame is being sent. Each start, data and parity bit lasts 16 ticks, which is 16 × max(divisor,1) clocks, counted from the clock in which the start bit appears.
- R4: When control bit 3 is 1, one parity bit follows the last data bit. When it is 0, no parity bit is sent.
- R5: Control bit 4 picks the parity sense: 1 makes the count of ones over the active data bits plus the parity bit even, and 0 makes it odd. Data bits above the selected length do not enter the parity.
- R6: With control bit 2 at 0, the stop period is one bit (16 ticks).
- R7: With control bit 2 at 1 and a 5-bit length, the stop period is 24 ticks.
- R8: With control bit 2 at 1 and a 6-, 7- or 8-bit length, the stop period is 32 ticks.
- R9: While control bit 7 is 1, writes to address 0 load the divisor low byte and writes to address 1 load the divisor high byte, and no frame starts. While it is 0, a write to address 1 leaves the divisor unchanged.
- R10: A divisor of 0 gives the same bit timing as a divisor of 1.
- R11: A byte written while a frame is in progress is held. Its start bit begins in the clock right after the current stop period ends, with no idle gap.
- R12: `thr_empty` goes to 0 in the clock after a holding-register write and returns to 1 when the byte moves into the shifter. `tx_idle` is 0 from the write until the stop period of the last frame ends.
- R13: The frame format is captured when the start bit begins. A control register write during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| txd | output | 1 | Serial output line, idle high |
| thr_empty | output | 1 | Holding register can accept a byte |
| tx_idle | output | 1 | No frame in progress and no byte pending |

## Verification
The assertions assume that `wr_en` is a single-clock strobe with a defined address and data. They also assume the host does not change the divisor during a frame, since the tick spacing is only meaningful while the divisor is stable. The stimulus writes the divisor and control register only while `tx_idle` is 1. The single exception is a deliberate mid-frame control write that exercises the format capture. Random frames draw the length, parity and stop selections from the five low control bits and keep the divisor at 0 to 4. Directed cases cover the divisor high byte, the divisor-select decoding and a back-to-back write.

// File: rtl/uart_tx_pkg.sv
// Shared widths, state encoding and format decoding for the UART transmit framer.
// Assumes an 8-bit host data path and a divisor made of two host bytes.
package uart_tx_pkg;

    localparam int DATA_W = 8;
    localparam int DIV_W  = 2 * DATA_W;
    localparam int TICK_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [3:0]        nbits;
        logic              par_en;
        logic [TICK_W-1:0] stop_ticks;
    } frame_cfg_t;

    // Turn control bits into a frame format for a given oversample ratio
    function automatic frame_cfg_t decode_cfg(input logic [DATA_W-1:0] ctl, input int osr);
        frame_cfg_t c;
        c.nbits  = 4'd5 + {2'b00, ctl[1:0]};
        c.par_en = ctl[3];
        if (!ctl[2])
            c.stop_ticks = TICK_W'(osr);
        else if (ctl[1:0] == 2'b00)
            c.stop_ticks = TICK_W'(osr + osr / 2);
        else
            c.stop_ticks = TICK_W'(2 * osr);
        return c;
    endfunction

    // Parity bit over the active data bits; even sense when 'even' is set
    function automatic logic calc_parity(input logic [DATA_W-1:0] d, input logic [1:0] len,
                                         input logic even);
        logic [DATA_W-1:0] mask;
        mask = DATA_W'(8'hFF >> (2'd3 - len));
        return even ? ^(d & mask) : ~^(d & mask);
    endfunction

endpackage

// File: rtl/uart_baud_gen.sv
// Oversample tick generator: one tick every max(divisor,1) clocks.
// Assumes the divisor is held steady while a frame is sent; 'clr' realigns
// the tick phase so that the first tick comes 'divisor' clocks after it.
module uart_baud_gen
    import uart_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             clr,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] eff_div;

    // Zero divisor behaves as one so the ticks never stop
    assign eff_div = (divisor == '0) ? DIV_W'(1) : divisor;
    assign tick    = (cnt >= eff_div - DIV_W'(1));

    // Count clocks between ticks, restarting on a tick or a realign request
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || tick)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end

    // R10
    zero_div_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |-> tick);

    // R3
    realign_first_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && divisor > DIV_W'(1)) |=> !tick);

endmodule

// File: rtl/uart_tx_regs.sv
// Host register file: control register, split divisor and one-deep holding register.
// Assumes one write per strobe; a write to the holding register wins over a
// same-cycle hand-off to the shifter.
module uart_tx_regs
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] ctl,
    output logic [DIV_W-1:0]  divisor,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_valid
);

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_DIVH = 2'd1;
    localparam logic [1:0] A_CTL  = 2'd3;

    logic div_sel;
    logic wr_hold;

    assign div_sel = ctl[7];
    assign wr_hold = wr_en && (wr_addr == A_DATA) && !div_sel;

    // Control register and divisor bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl     <= 8'h03;
            divisor <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTL)
                ctl <= wr_data;
            else if (wr_addr == A_DATA && div_sel)
                divisor[DATA_W-1:0] <= wr_data;
            else if (wr_addr == A_DIVH && div_sel)
                divisor[DIV_W-1:DATA_W] <= wr_data;
        end
    end

    // Holding register: filled by host writes, emptied when the shifter takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data  <= '0;
            hold_valid <= 1'b0;
        end else if (wr_hold) begin
            hold_data  <= wr_data;
            hold_valid <= 1'b1;
        end else if (take) begin
            hold_valid <= 1'b0;
        end
    end

    // R12
    take_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> hold_valid);

    // R9
    div_write_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DATA && div_sel && !hold_valid) |=> !hold_valid);

    // R9
    divh_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DIVH && !div_sel) |=> $stable(divisor));

endmodule

// File: rtl/uart_tx_shifter.sv
// Frame sequencer: start bit, data bits LSB first, optional parity, stop period.
// Assumes 'tick' is the oversample enable and that the format and byte inputs
// are valid in the cycle 'take' is raised; both are captured there.
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DATA_W-1:0] ctl,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_valid,
    output logic              take,
    output logic              busy,
    output logic              txd
);

    tx_state_e         state;
    frame_cfg_t        cfg_q;
    logic [DATA_W-1:0] shreg;
    logic [3:0]        bit_idx;
    logic [TICK_W-1:0] tcnt;
    logic [TICK_W-1:0] limit;
    logic              par_q;
    logic              last_tick;

    // Ticks that make up the current bit
    assign limit     = (state == ST_STOP) ? cfg_q.stop_ticks : TICK_W'(OSR);
    assign last_tick = tick && (tcnt == limit - TICK_W'(1));
    assign take      = hold_valid &&
                       ((state == ST_IDLE) || (state == ST_STOP && last_tick));
    assign busy      = (state != ST_IDLE);

    // Line level for each part of the frame
    always_comb begin
        case (state)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_q;
            default:   txd = 1'b1;
        endcase
    end

    // Step through the frame one bit period at a time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cfg_q   <= '0;
            shreg   <= '0;
            bit_idx <= '0;
            tcnt    <= '0;
            par_q   <= 1'b0;
        end else if (take) begin
            state   <= ST_START;
            cfg_q   <= decode_cfg(ctl, OSR);
            shreg   <= hold_data;
            par_q   <= calc_parity(hold_data, ctl[1:0], ctl[4]);
            bit_idx <= '0;
            tcnt    <= '0;
        end else if (state != ST_IDLE && tick) begin
            if (last_tick) begin
                tcnt <= '0;
                case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        if (bit_idx == cfg_q.nbits - 4'd1)
                            state <= cfg_q.par_en ? ST_PARITY : ST_STOP;
                        else
                            bit_idx <= bit_idx + 4'd1;
                    end
                    ST_PARITY: state <= ST_STOP;
                    default:   state <= ST_IDLE;
                endcase
            end else begin
                tcnt <= tcnt + TICK_W'(1);
            end
        end
    end

    // R3
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R2
    data_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (bit_idx < cfg_q.nbits));

    // R11
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && last_tick && hold_valid) |=> (state == ST_START));

    // R13
    format_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !take) |=> $stable(cfg_q));

    // R4
    parity_only_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARITY) |-> cfg_q.par_en);

endmodule

// File: rtl/uart_tx_framer.sv
// Top of the UART transmit framer: register file, tick generator and frame sequencer.
// Assumes the host changes the divisor only while tx_idle is high.
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       txd,
    output logic       thr_empty,
    output logic       tx_idle
);

    logic [DATA_W-1:0] ctl;
    logic [DIV_W-1:0]  divisor;
    logic [DATA_W-1:0] hold_data;
    logic              hold_valid;
    logic              take;
    logic              busy;
    logic              tick;

    uart_tx_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .take       (take),
        .ctl        (ctl),
        .divisor    (divisor),
        .hold_data  (hold_data),
        .hold_valid (hold_valid)
    );

    uart_baud_gen u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .clr     (take),
        .tick    (tick)
    );

    uart_tx_shifter #(.OSR(OSR)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .ctl        (ctl),
        .hold_data  (hold_data),
        .hold_valid (hold_valid),
        .take       (take),
        .busy       (busy),
        .txd        (txd)
    );

    assign thr_empty = !hold_valid;
    assign tx_idle   = !hold_valid && !busy;

    // R12
    idle_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> thr_empty);

endmodule

// File: tb/uart_tx_framer_bench.sv
module uart_tx_framer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       txd, thr_empty, tx_idle;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    uart_tx_framer u_uart_tx_framer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .txd(txd), .thr_empty(thr_empty), .tx_idle(tx_idle)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int eff(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic int nbits(input logic [7:0] l);
        return 5 + int'(l[1:0]);
    endfunction

    function automatic int stop_ticks(input logic [7:0] l);
        if (!l[2]) return 16;
        return (l[1:0] == 2'b00) ? 24 : 32;
    endfunction

    // Number of bit slots before the stop period: start, data, parity
    function automatic int head_bits(input logic [7:0] l);
        return 1 + nbits(l) + int'(l[3]);
    endfunction

    function automatic int frame_clocks(input logic [7:0] l, input int d);
        return (16 * head_bits(l) + stop_ticks(l)) * eff(d);
    endfunction

    // Expected line level in bit slot i (slot head_bits is the stop period)
    function automatic logic exp_bit(input logic [7:0] l, input logic [7:0] d, input int i);
        int n = nbits(l);
        logic p = 1'b0;
        if (i == 0) return 1'b0;
        if (i <= n) return d[i-1];
        for (int b = 0; b < n; b++) p ^= d[b];
        if (l[3] && i == n + 1) return l[4] ? p : ~p;
        return 1'b1;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic config_line(input logic [7:0] l, input int d);
        wr(2'd3, 8'h80 | l);
        wr(2'd0, d[7:0]);
        wr(2'd1, d[15:8]);
        wr(2'd3, l);
    endtask

    // Called at the negedge where the start bit is first seen; samples every slot mid-bit
    task automatic check_body(input logic [7:0] l, input int d, input logic [7:0] data,
                              input string req);
        int k = 0;
        int bad = -1;
        logic got = 1'b1;
        for (int i = 0; i <= head_bits(l); i++) begin
            int target = 16 * eff(d) * i + 8 * eff(d);
            while (k < target) begin @(negedge clk); k++; end
            if (txd !== exp_bit(l, data, i) && bad < 0) begin bad = i; got = txd; end
        end
        check(bad < 0, req, $sformatf("frame slot %0d lcr=%02h data=%02h", bad, l, data),
              int'(got), (bad < 0) ? 0 : int'(exp_bit(l, data, bad)));
    endtask

    task automatic wait_fall(output int t0);
        int n = 0;
        while (txd !== 1'b0 && n < 100) begin @(negedge clk); n++; end
        t0 = cyc;
        check(txd === 1'b0, "R3", "start bit appears", int'(txd), 0);
    endtask

    task automatic wait_idle_len(input int t0, input int exp, input string req);
        int n = 0;
        while (tx_idle !== 1'b1 && n < 70000) begin @(negedge clk); n++; end
        check(cyc - t0 == exp, req, "frame length in clocks", cyc - t0, exp);
    endtask

    task automatic send(input logic [7:0] l, input int d, input logic [7:0] data,
                        input string req);
        int t0;
        wr(2'd0, data);
        check(thr_empty === 1'b0 && tx_idle === 1'b0, "R12", "flags after write",
              int'({thr_empty, tx_idle}), 0);
        @(negedge clk);
        wait_fall(t0);
        check(thr_empty === 1'b1, "R12", "empty once byte taken", int'(thr_empty), 1);
        check_body(l, d, data, req);
        wait_idle_len(t0, frame_clocks(l, d), req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t0, t1;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd === 1'b1 && thr_empty === 1'b1 && tx_idle === 1'b1, "R1", "reset outputs",
              int'({txd, thr_empty, tx_idle}), 7);

        // R1 / R10: reset format is 8N1 with divisor 0 acting as 1
        send(8'h03, 0, 8'hA5, "R1");

        // R10: explicit divisor 1 matches divisor 0
        config_line(8'h03, 1);
        send(8'h03, 1, 8'h3C, "R10");

        // R9: divisor select on, address 0 must not start a frame
        config_line(8'h00, 3);
        wr(2'd3, 8'h80);
        wr(2'd0, 8'h02);
        wr(2'd3, 8'h00);
        repeat (10) @(negedge clk);
        check(thr_empty === 1'b1 && txd === 1'b1, "R9", "no frame from divisor write",
              int'({thr_empty, txd}), 3);
        // R9: address 1 without divisor select leaves the divisor at 2
        wr(2'd1, 8'h05);
        send(8'h00, 2, 8'h15, "R9");

        // R7, R8, R6 and R2 directed stop/length cases
        config_line(8'h04, 2);  send(8'h04, 2, 8'h1B, "R7");
        config_line(8'h05, 1);  send(8'h05, 1, 8'h2D, "R8");
        config_line(8'h07, 1);  send(8'h07, 1, 8'hC3, "R8");
        config_line(8'h02, 1);  send(8'h02, 1, 8'hFF, "R2");
        config_line(8'h01, 1);  send(8'h01, 1, 8'hE0, "R6");

        // R4 / R5: parity senses with bits above the length set
        config_line(8'h18, 1);  send(8'h18, 1, 8'hE1, "R5");
        config_line(8'h08, 1);  send(8'h08, 1, 8'hE1, "R5");
        config_line(8'h1B, 2);  send(8'h1B, 2, 8'h00, "R4");

        // R9: high divisor byte gives 256
        config_line(8'h00, 256);
        send(8'h00, 256, 8'h0A, "R9");

        // R11 back-to-back: second byte written mid-frame starts right after stop
        config_line(8'h0E, 1);
        wr(2'd0, 8'h96);
        @(negedge clk);
        wait_fall(t0);
        fork
            check_body(8'h0E, 1, 8'h96, "R11");
            begin repeat (20) @(negedge clk); wr(2'd0, 8'h69); end
        join
        check(thr_empty === 1'b0, "R12", "second byte pending", int'(thr_empty), 0);
        while (thr_empty !== 1'b1) @(negedge clk);
        t1 = cyc;
        check(t1 - t0 == frame_clocks(8'h0E, 1), "R11", "no gap between frames",
              t1 - t0, frame_clocks(8'h0E, 1));
        check(txd === 1'b0, "R11", "second start bit", int'(txd), 0);
        check_body(8'h0E, 1, 8'h69, "R11");
        wait_idle_len(t1, frame_clocks(8'h0E, 1), "R11");

        // R13: control write mid-frame affects only this frame's successor
        config_line(8'h1F, 1);
        wr(2'd0, 8'h5A);
        @(negedge clk);
        wait_fall(t0);
        fork
            check_body(8'h1F, 1, 8'h5A, "R13");
            begin repeat (30) @(negedge clk); wr(2'd3, 8'h00); end
        join
        wait_idle_len(t0, frame_clocks(8'h1F, 1), "R13");
        send(8'h00, 1, 8'h5A, "R13");

        // Random formats, data and divisors
        for (int r = 0; r < 30; r++) begin
            logic [7:0] l = 8'($urandom % 32);
            int d = int'($urandom % 5);
            logic [7:0] data = 8'($urandom);
            config_line(l, d);
            send(l, d, data, "R3");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule